// File: doc/BRIEF.md
# Serial Flash Boot-Stream Sequencer

This block sits on the device side of a serial-flash link. It lets a host fetch boot code right after reset without sending a command. After every reset the sequencer is armed. On the first chip-select assertion it does one of two things. If boot streaming is enabled, it waits a programmed number of SCK cycles with its data pins released. It then reads a byte-wide synchronous memory from a 512-byte-aligned start address and shifts the bytes out until chip-select is released. Data goes out either one bit per SCK cycle on a single line, or one nibble per SCK cycle on four lines. When chip-select rises, the block gives the link over to normal command mode and stays there until the next reset.

All logic runs on a system clock `clk`, which must be much faster than SCK. Chip-select and SCK pass through two synchronizer stages and an edge detector. Output bits change after a detected SCK falling edge, so the host can sample them on the following rising edge. One byte is always prefetched ahead of the byte being shifted, so the stream never stalls at byte boundaries.

Timing assumptions on the host side:
- The SCK high and low phases each last at least six `clk` periods.
- The first SCK rising edge comes no earlier than ten `clk` periods after chip-select falls.

Top module: `boot_stream_seq`

## Requirements
- R1: While reset is held and right after it is released, `dataOe`, `dataOut`, `bootDone` and `shortXferErr` are all 0.
- R2: If `bootEnable` is 0 at the first chip-select fall after reset, the block enters command mode (`bootDone`=1) without issuing any memory read, and `dataOe` stays 0.
- R3: The first byte streamed is read from byte address `bootStartBlk` shifted left by 9 (the low 9 bits are zero). Each later byte comes from the next address up. The address wraps from the top of the `ADDR_W`-bit space to 0.
- R4: With a delay value N on `bootDelay`, `dataOe` is 0 for the first N SCK rising edges after chip-select falls. The first data unit is valid at rising edge N+1. With N=0, that is the first rising edge.
- R5: When `bootQuad`=0, each byte leaves on `dataOut[0]` MSB first, one bit per SCK cycle, and `dataOut[3:1]` is 0.
- R6: When `bootQuad`=1, each byte leaves as two nibbles on `dataOut[3:0]`, bits [7:4] first, then bits [3:0].
- R7: Bytes follow each other with no gap SCK cycles for as long as chip-select stays low. `dataOe` stays 1 throughout.
- R8: A chip-select rise during the wait or the stream sets `bootDone`=1 and drops `dataOe` to 0. Until the next reset, further chip-select and SCK activity produce no memory reads and no driven output.
- R9: If chip-select rises before the first whole byte has been clocked out, `shortXferErr` becomes 1 and holds until reset. This includes a rise during the wait. After at least one whole byte, `shortXferErr` stays 0.
- R10: A reset clears `bootDone` and `shortXferErr` and arms the block again for one more boot stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rstN | input | 1 | Asynchronous active-low reset, re-arms boot streaming |
| csN | input | 1 | Chip select from host, active low |
| sck | input | 1 | Serial clock from host, idles low |
| bootEnable | input | 1 | Boot streaming allowed |
| bootStartBlk | input | 23 | Start location in 512-byte units |
| bootDelay | input | 8 | Number of SCK wait cycles before data |
| bootQuad | input | 1 | 1: four bits per SCK cycle, 0: one bit |
| memAddr | output | ADDR_W | Memory read address |
| memRdEn | output | 1 | Memory read strobe, data one clock later |
| memRdData | input | 8 | Memory read data |
| dataOut | output | 4 | Serial data pins; bit 0 is the single-line output |
| dataOe | output | 1 | Output enable for the data pins |
| bootDone | output | 1 | Block has handed over to command mode |
| shortXferErr | output | 1 | Chip select released before one whole byte |

## Verification
The hardest condition to reach from the ports is the address wrap. It needs a stream longer than the whole array. The bench therefore builds the block with a 10-bit address. It starts at the upper 512-byte half and streams 514 bytes in four-bit mode, which crosses the top in about a thousand SCK cycles. The other awkward cases are the early releases: a release inside the wait window, and a release three bits into the first byte. The bench reaches them by raising chip-select after a chosen count of SCK cycles. It then keeps clocking SCK to show that the block does not stream again.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  localparam int ALIGN_BITS = 9;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    ST_ARMED,
    ST_WAIT,
    ST_STREAM,
    ST_DONE
  } bootState_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic start;     // begin a boot stream, fetch first byte
    logic loadNext;  // byte boundary: take prefetched byte
    logic shift;     // advance within the current byte
    logic quad;      // four bits per SCK cycle
    logic drive;     // data pins enabled
  } dpStrobe_t;

endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import spi_boot_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sck,
  input  logic               bootEnable,
  input  logic [DELAY_W-1:0] bootDelay,
  input  logic               bootQuad,
  output dpStrobe_t          strb,
  output logic               bootDone,
  output logic               shortXferErr
);

  // [0],[1] synchronizer, [2] previous value for edge detection
  logic [2:0] csSync;
  logic [2:0] sckSync;
  logic csFall, csRise, sckRise, sckFall;

  bootState_t         state;
  logic [DELAY_W-1:0] waitCnt;
  logic [2:0]         unitIdx;
  logic [2:0]         unitLast;
  logic               byteEnd;
  logic               gotByte;
  logic               quadQ;
  logic               shortErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= 3'b111;
      sckSync <= 3'b000;
    end else begin
      csSync  <= {csSync[1:0], csN};
      sckSync <= {sckSync[1:0], sck};
    end
  end

  assign csFall  = csSync[2] & ~csSync[1];
  assign csRise  = ~csSync[2] & csSync[1];
  assign sckRise = ~sckSync[2] & sckSync[1] & ~csSync[1];
  assign sckFall = sckSync[2] & ~sckSync[1] & ~csSync[1];

  assign unitLast = quadQ ? 3'd1 : 3'd7;

  always_comb begin
    strb          = '0;
    strb.quad     = quadQ;
    strb.drive    = (state == ST_STREAM);
    strb.start    = (state == ST_ARMED) && csFall && bootEnable;
    strb.loadNext = (state == ST_STREAM) && !csRise && sckFall && byteEnd;
    strb.shift    = (state == ST_STREAM) && !csRise && sckFall && !byteEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ARMED;
      waitCnt  <= '0;
      unitIdx  <= '0;
      byteEnd  <= 1'b0;
      gotByte  <= 1'b0;
      quadQ    <= 1'b0;
      shortErr <= 1'b0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (csFall) begin
            if (bootEnable) begin
              quadQ   <= bootQuad;
              waitCnt <= bootDelay;
              unitIdx <= '0;
              byteEnd <= 1'b0;
              gotByte <= 1'b0;
              state   <= (bootDelay == '0) ? ST_STREAM : ST_WAIT;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_WAIT: begin
          if (csRise) begin
            shortErr <= 1'b1;
            state    <= ST_DONE;
          end else if (sckFall) begin
            waitCnt <= waitCnt - DELAY_W'(1);
            if (waitCnt == DELAY_W'(1)) state <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (csRise) begin
            shortErr <= !gotByte;
            state    <= ST_DONE;
          end else begin
            if (sckRise) begin
              if (unitIdx == unitLast) begin
                unitIdx <= '0;
                byteEnd <= 1'b1;
                gotByte <= 1'b1;
              end else begin
                unitIdx <= unitIdx + 3'd1;
              end
            end
            if (sckFall) byteEnd <= 1'b0;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign bootDone     = (state == ST_DONE);
  assign shortXferErr = shortErr;

  // R8: command mode is kept until the next reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE |=> state == ST_DONE);

  // R8: a release during wait or stream ends driving at once
  assert_release_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && (state == ST_WAIT || state == ST_STREAM)) |=> (bootDone && !strb.drive));

  // R9: violation flag holds once raised
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    shortErr |=> shortErr);

  // R7: at most one datapath action per clock
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.start, strb.loadNext, strb.shift}));

endmodule

// File: rtl/boot_dp.sv
module boot_dp
  import spi_boot_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int START_W = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [START_W-1:0] bootStartBlk,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRdEn,
  input  logic [BYTE_W-1:0]  memRdData,
  output logic [3:0]         dataOut,
  output logic               dataOe
);

  localparam int FULL_W = START_W + ALIGN_BITS;

  logic [FULL_W-1:0] baseFull;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              rdEnQ;
  logic              fillFirst;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] nextByte;

  assign baseFull = {bootStartBlk, {ALIGN_BITS{1'b0}}};
  assign baseAddr = baseFull[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memRdEn   <= 1'b0;
      nextAddr  <= '0;
      rdEnQ     <= 1'b0;
      fillFirst <= 1'b0;
      shiftReg  <= '0;
      nextByte  <= '0;
    end else begin
      memRdEn <= 1'b0;
      rdEnQ   <= memRdEn;
      if (strb.start) begin
        memAddr   <= baseAddr;
        memRdEn   <= 1'b1;
        nextAddr  <= baseAddr + ADDR_W'(1);
        fillFirst <= 1'b1;
        shiftReg  <= '0;
      end else begin
        if (rdEnQ) begin
          if (fillFirst) begin
            // first byte lands in the shifter, then prefetch one ahead
            shiftReg  <= memRdData;
            fillFirst <= 1'b0;
            memAddr   <= nextAddr;
            memRdEn   <= 1'b1;
            nextAddr  <= nextAddr + ADDR_W'(1);
          end else begin
            nextByte <= memRdData;
          end
        end
        if (strb.loadNext) begin
          shiftReg <= nextByte;
          memAddr  <= nextAddr;
          memRdEn  <= 1'b1;
          nextAddr <= nextAddr + ADDR_W'(1);
        end else if (strb.shift) begin
          shiftReg <= strb.quad ? {shiftReg[3:0], 4'b0000} : {shiftReg[6:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    if (!strb.drive)    dataOut = 4'b0000;
    else if (strb.quad) dataOut = shiftReg[7:4];
    else                dataOut = {3'b000, shiftReg[7]};
  end
  assign dataOe = strb.drive;

  // R3: each memory request is a single-clock strobe
  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

endmodule

// File: rtl/boot_stream_seq.sv
module boot_stream_seq
  import spi_boot_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int START_W = 23,
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sck,
  input  logic               bootEnable,
  input  logic [START_W-1:0] bootStartBlk,
  input  logic [DELAY_W-1:0] bootDelay,
  input  logic               bootQuad,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRdEn,
  input  logic [7:0]         memRdData,
  output logic [3:0]         dataOut,
  output logic               dataOe,
  output logic               bootDone,
  output logic               shortXferErr
);

  dpStrobe_t strb;

  boot_ctrl #(.DELAY_W(DELAY_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .csN          (csN),
    .sck          (sck),
    .bootEnable   (bootEnable),
    .bootDelay    (bootDelay),
    .bootQuad     (bootQuad),
    .strb         (strb),
    .bootDone     (bootDone),
    .shortXferErr (shortXferErr)
  );

  boot_dp #(.ADDR_W(ADDR_W), .START_W(START_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .bootStartBlk (bootStartBlk),
    .memAddr      (memAddr),
    .memRdEn      (memRdEn),
    .memRdData    (memRdData),
    .dataOut      (dataOut),
    .dataOe       (dataOe)
  );

endmodule

// File: tb/tb_boot_stream_seq.sv
module tb_boot_stream_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // clk periods per SCK phase
  localparam int ADDR_W     = 10;

  // vector: {quad, delay[7:0], startBlk[22:0], nBytes[7:0]}
  localparam logic [39:0] VEC [5] = '{
    {1'b0, 8'd0,   23'd0, 8'd3},
    {1'b0, 8'd5,   23'd1, 8'd4},
    {1'b1, 8'd0,   23'd1, 8'd4},
    {1'b1, 8'd8,   23'd0, 8'd3},
    {1'b0, 8'd255, 23'd3, 8'd2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              csN = 1'b1;
  logic              sck = 1'b0;
  logic              bootEnable = 1'b1;
  logic [22:0]       bootStartBlk = '0;
  logic [7:0]        bootDelay = '0;
  logic              bootQuad = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRdEn;
  logic [7:0]        memRdData = '0;
  logic [3:0]        dataOut;
  logic              dataOe;
  logic              bootDone;
  logic              shortXferErr;

  int nChecks = 0;
  int nErrors = 0;
  int memReads = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_stream_seq #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck),
    .bootEnable(bootEnable), .bootStartBlk(bootStartBlk),
    .bootDelay(bootDelay), .bootQuad(bootQuad),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .dataOut(dataOut), .dataOe(dataOe),
    .bootDone(bootDone), .shortXferErr(shortXferErr)
  );

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    return 8'((ai * 37) ^ (ai >> 2));
  endfunction

  // synchronous memory model, one clock read latency
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memByte(memAddr);
      memReads  <= memReads + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    csN = 1'b1;
    sck = 1'b0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one SCK period: sample just before the rising edge
  task automatic sckCycle(output logic [3:0] d, output logic oe);
    repeat (HALF) @(negedge clk);
    d  = dataOut;
    oe = dataOe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic csHigh();
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic runBoot(input bit q, input int dly, input logic [22:0] blk,
                         input int nBytes);
    logic [3:0]        d;
    logic              oe;
    int                waitBad;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        got;
    int                hiBad;
    int                oeBad;
    logic [31:0]       baseFull;
    bootQuad     = q;
    bootDelay    = 8'(dly);
    bootStartBlk = blk;
    bootEnable   = 1'b1;
    csN = 1'b0;
    repeat (4) @(negedge clk);
    waitBad = 0;
    for (int i = 0; i < dly; i++) begin
      sckCycle(d, oe);
      if (oe) waitBad++;
    end
    check(waitBad == 0, "R4", "output enabled during wait cycles", waitBad, 0);
    baseFull = {blk, 9'b0};
    addr = baseFull[ADDR_W-1:0];
    for (int b = 0; b < nBytes; b++) begin
      got = '0; hiBad = 0; oeBad = 0;
      for (int u = 0; u < (q ? 2 : 8); u++) begin
        sckCycle(d, oe);
        if (!oe) oeBad++;
        if (q) got = {got[3:0], d};
        else begin
          got = {got[6:0], d[0]};
          if (d[3:1] != 3'b000) hiBad++;
        end
      end
      check(got == memByte(addr), q ? "R3/R6/R7" : "R3/R5/R7",
            $sformatf("byte %0d at addr %0h", b, addr), got, memByte(addr));
      if (oeBad != 0 || hiBad != 0)
        check(1'b0, "R7/R5", $sformatf("byte %0d enable/upper bits", b),
              oeBad + hiBad, 0);
      addr = addr + ADDR_W'(1);
    end
  endtask

  initial begin
    logic [3:0] d;
    logic       oe;
    int         oeSeen;
    int         readsBefore;

    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(dataOe == 1'b0 && dataOut == 4'h0, "R1", "pins during reset",
          {dataOe, dataOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(bootDone == 1'b0 && shortXferErr == 1'b0, "R1", "status after reset",
          {bootDone, shortXferErr}, 0);
    check(memReads == 0, "R1", "reads after reset", memReads, 0);

    // table of boot streams
    for (int v = 0; v < 5; v++) begin
      doReset();
      runBoot(VEC[v][39], int'(VEC[v][38:31]), VEC[v][30:8], int'(VEC[v][7:0]));
      csHigh();
      check(bootDone == 1'b1 && dataOe == 1'b0, "R8",
            $sformatf("vector %0d handover", v), {bootDone, dataOe}, 2);
      check(shortXferErr == 1'b0, "R9", $sformatf("vector %0d no error", v),
            shortXferErr, 0);
    end

    // R2: enable clear
    doReset();
    bootEnable = 1'b0;
    readsBefore = memReads;
    csN = 1'b0;
    oeSeen = 0;
    for (int i = 0; i < 12; i++) begin
      sckCycle(d, oe);
      if (oe) oeSeen++;
    end
    check(oeSeen == 0, "R2", "output with enable clear", oeSeen, 0);
    check(memReads == readsBefore, "R2", "reads with enable clear",
          memReads - readsBefore, 0);
    check(bootDone == 1'b1, "R2", "command mode with enable clear", bootDone, 1);
    csHigh();
    bootEnable = 1'b1;

    // R9: release inside the wait window
    doReset();
    bootQuad = 1'b0; bootDelay = 8'd4; bootStartBlk = 23'd0;
    csN = 1'b0;
    repeat (4) @(negedge clk);
    sckCycle(d, oe);
    sckCycle(d, oe);
    csHigh();
    check(shortXferErr == 1'b1, "R9", "release during wait", shortXferErr, 1);

    // R9: release three bits into the first byte
    doReset();
    bootDelay = 8'd0;
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) sckCycle(d, oe);
    csHigh();
    check(shortXferErr == 1'b1, "R9", "release mid first byte", shortXferErr, 1);
    check(bootDone == 1'b1 && dataOe == 1'b0, "R8", "handover after short",
          {bootDone, dataOe}, 2);

    // R8: no second boot stream without reset
    readsBefore = memReads;
    csN = 1'b0;
    oeSeen = 0;
    for (int i = 0; i < 16; i++) begin
      sckCycle(d, oe);
      if (oe) oeSeen++;
    end
    check(oeSeen == 0, "R8", "output on second select", oeSeen, 0);
    check(memReads == readsBefore, "R8", "reads on second select",
          memReads - readsBefore, 0);
    check(shortXferErr == 1'b1, "R9", "flag holds", shortXferErr, 1);
    csHigh();

    // R10: reset re-arms, exactly one byte then release
    doReset();
    check(shortXferErr == 1'b0 && bootDone == 1'b0, "R10", "status cleared",
          {bootDone, shortXferErr}, 0);
    runBoot(1'b0, 3, 23'd1, 1);
    csHigh();
    check(shortXferErr == 1'b0, "R9", "one whole byte is enough", shortXferErr, 0);
    check(bootDone == 1'b1, "R10", "handover after re-armed stream", bootDone, 1);

    // R3: stream across the top of the array
    doReset();
    runBoot(1'b1, 0, 23'd1, 514);
    csHigh();
    check(bootDone == 1'b1, "R3", "handover after wrap stream", bootDone, 1);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule